// File: doc/BRIEF.md
# Multiplicative Order of Two Engine

This engine takes an odd candidate p, typically delivered by an upstream sieve, and searches for the smallest exponent e with 2^e ≡ 1 (mod p). It uses no multiplier. A residue register is doubled once per clock. When the doubled value reaches p, p is subtracted. The test for a unit residue runs only on the cycles where that subtraction happened, because a doubled value below p is even and cannot be 1. An iteration cap is loaded with each job, and a search that would pass the cap is abandoned.

When an exponent is found, a secondary filter checks whether e divides p − 1. It starts from 1 − p and adds e once per clock, counting the additions, until the running sum becomes strictly positive. It then subtracts e once. A zero result means e divides p − 1, and the quotient is the addition count minus one. Each job is started with a single-cycle `start` while the engine is idle. It ends with a single-cycle `done`, and the result stays on the outputs until the next result replaces it.

Top module: `ord2_engine`

## Requirements
- R1: After reset the engine is idle (`busy` = 0), `done` is low, and `resCode`, `pOut`, `eOut` and `fOut` are all zero.
- R2: A start with p < 3 or p even finishes on the clock that samples `start` with `resCode` = 3. `pOut` is the offered p, and `eOut` = `fOut` = 0.
- R3: The residue is 2 for n = 1, and each step forms 2r − p when 2r ≥ p, else 2r. The first n at which a subtracted result equals 1 becomes `eOut`, and that value is the smallest n ≥ 2 with 2^n mod p = 1.
- R4: When no such n exists with n ≤ cap (cap = `capIn` sampled with `start`), the job ends with `resCode` = 1 and `eOut` = `fOut` = 0.
- R5: When e divides p − 1, the job ends with `resCode` = 0 and `fOut` = (p − 1)/e.
- R6: When e does not divide p − 1, the job ends with `resCode` = 2, `eOut` = e and `fOut` = 0.
- R7: Each doubling step and each divisibility step takes one clock. Counting the edge that samples `start` as edge 1, `done` rises after edge 1 for a rejected input and after edge 1 + max(cap, 1) when the cap is exceeded. A found exponent raises `done` after edge e + k + 1, where k = floor((p − 1)/e) + 1.
- R8: `done` is high for exactly one cycle and `busy` is low while it is high. The result outputs are unchanged in the cycle after `done`.
- R9: A `start` pulse while `busy` is high is ignored, and the running job's result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a job when the engine is idle |
| pIn | input | PW (16) | Candidate modulus |
| capIn | input | CW (12) | Largest exponent the search may report |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job strobe |
| resCode | output | 2 | 0 accepted, 1 cap exceeded, 2 no division, 3 bad input |
| pOut | output | PW (16) | Modulus of the last job |
| eOut | output | CW (12) | Exponent found, or zero |
| fOut | output | PW (16) | Quotient (p − 1)/e when accepted, or zero |

## Verification
The hardest outcome to reach from the ports is a composite odd p whose order of two fails to divide p − 1. The bench reaches it with small composites such as 9, 15 and 21, and with 65535 at the full width. The cap boundary is approached from both sides: 341 has order 10 and is run with caps 9 and 10, and 7 is run with caps 2 and 3. A sweep over every odd p below 200 covers the remaining orders. A foreign `start` with a different p is pushed into the long run for p = 101 to confirm that the running job ignores it.

// File: rtl/ord2_pkg.sv
package ord2_pkg;

  typedef enum logic [1:0] {
    RC_ACCEPT = 2'd0,
    RC_CAPX   = 2'd1,
    RC_NODIV  = 2'd2,
    RC_BADIN  = 2'd3
  } resCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     stepDbl;
    logic     initDiv;
    logic     stepDiv;
    logic     finish;
    resCode_e code;
  } ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic inBad;
    logic capHit;
    logic unitHit;
    logic divLast;
    logic divExact;
  } stat_t;

endpackage

// File: rtl/ord2_datapath.sv
module ord2_datapath
  import ord2_pkg::*;
#(
  parameter int PW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [PW-1:0] pIn,
  input  logic [CW-1:0] capIn,
  output stat_t         stat,
  output logic [1:0]    resCode,
  output logic [PW-1:0] pOut,
  output logic [CW-1:0] eOut,
  output logic [PW-1:0] fOut
);

  localparam int NW = CW + 1;   // counter may reach cap + 1
  localparam int AW = PW + 1;   // signed running sum / doubled residue

  logic [PW-1:0] pReg, resid, qCnt;
  logic [CW-1:0] capReg, eReg;
  logic [NW-1:0] nCnt, nNext;
  logic signed [AW-1:0] acc, eExt, accAdd, accSub;
  logic [AW-1:0] dbl, red;
  logic geP;

  // modular doubling
  assign dbl   = {resid, 1'b0};
  assign geP   = dbl >= {1'b0, pReg};
  assign red   = geP ? (dbl - {1'b0, pReg}) : dbl;
  assign nNext = nCnt + NW'(1);

  // divisibility arithmetic
  assign eExt   = $signed({{(AW-CW){1'b0}}, eReg});
  assign accAdd = acc + eExt;
  assign accSub = acc - eExt;

  assign stat.inBad    = (pIn < PW'(3)) || !pIn[0];
  assign stat.capHit   = nNext > {1'b0, capReg};
  assign stat.unitHit  = geP && (red == AW'(1));
  assign stat.divLast  = !accAdd[AW-1] && (accAdd != '0);
  assign stat.divExact = accSub == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pReg <= '0; capReg <= '0; resid <= '0; nCnt <= '0;
      eReg <= '0; acc <= '0; qCnt <= '0;
      resCode <= '0; pOut <= '0; eOut <= '0; fOut <= '0;
    end else begin
      if (ctrl.load) begin
        pReg   <= pIn;
        capReg <= capIn;
        resid  <= PW'(2);
        nCnt   <= NW'(1);
      end
      if (ctrl.stepDbl) begin
        resid <= red[PW-1:0];
        nCnt  <= nNext;
      end
      if (ctrl.initDiv) begin
        eReg <= nNext[CW-1:0];
        acc  <= AW'(1) - {1'b0, pReg};
        qCnt <= '0;
      end
      if (ctrl.stepDiv) begin
        acc  <= accAdd;
        qCnt <= qCnt + PW'(1);
      end
      if (ctrl.finish) begin
        resCode <= ctrl.code;
        pOut    <= (ctrl.code == RC_BADIN) ? pIn : pReg;
        eOut    <= (ctrl.code == RC_ACCEPT || ctrl.code == RC_NODIV) ? eReg : '0;
        fOut    <= (ctrl.code == RC_ACCEPT) ? (qCnt - PW'(1)) : '0;
      end
    end
  end

  // R3: residue stays a nonzero value below p while doubling
  a_r3_resid_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepDbl |-> (resid < pReg) && (resid != '0));

  // R7: one count per doubling clock
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepDbl |=> nCnt == $past(nCnt) + NW'(1));

  // R5/R6: division loop only runs on a nonpositive sum
  a_r6_div_nonpos: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepDiv |-> (acc[AW-1] || acc == '0));

  // R8: results hold between finishes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.finish |=> $stable(resCode) && $stable(pOut) && $stable(eOut) && $stable(fOut));

endmodule

// File: rtl/ord2_ctrl.sv
module ord2_ctrl
  import ord2_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  stat_t stat,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);

  typedef enum logic [1:0] {S_IDLE, S_DBL, S_DIV, S_CHK} state_e;
  state_e state, stateNx;

  always_comb begin
    ctrl    = '0;
    stateNx = state;
    unique case (state)
      S_IDLE: if (start) begin
        if (stat.inBad) begin
          ctrl.finish = 1'b1;
          ctrl.code   = RC_BADIN;
        end else begin
          ctrl.load = 1'b1;
          stateNx   = S_DBL;
        end
      end
      S_DBL: begin
        if (stat.capHit) begin
          ctrl.finish = 1'b1;
          ctrl.code   = RC_CAPX;
          stateNx     = S_IDLE;
        end else if (stat.unitHit) begin
          ctrl.initDiv = 1'b1;
          stateNx      = S_DIV;
        end else begin
          ctrl.stepDbl = 1'b1;
        end
      end
      S_DIV: begin
        ctrl.stepDiv = 1'b1;
        if (stat.divLast) stateNx = S_CHK;
      end
      S_CHK: begin
        ctrl.finish = 1'b1;
        ctrl.code   = stat.divExact ? RC_ACCEPT : RC_NODIV;
        stateNx     = S_IDLE;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNx;
      done  <= ctrl.finish;
    end
  end

  assign busy = state != S_IDLE;

  // R8: done is a single-cycle strobe seen only when idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2: bad input answers on the next cycle without going busy
  a_r2_bad_fast: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && stat.inBad) |=> done && !busy);

  // R9: a start seen while busy does not restart the search
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctrl.load);

endmodule

// File: rtl/ord2_engine.sv
module ord2_engine
  import ord2_pkg::*;
#(
  parameter int PW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [PW-1:0] pIn,
  input  logic [CW-1:0] capIn,
  output logic          busy,
  output logic          done,
  output logic [1:0]    resCode,
  output logic [PW-1:0] pOut,
  output logic [CW-1:0] eOut,
  output logic [PW-1:0] fOut
);

  ctrl_t ctrl;
  stat_t stat;

  ord2_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  ord2_datapath #(.PW(PW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pIn(pIn), .capIn(capIn),
    .stat(stat), .resCode(resCode), .pOut(pOut), .eOut(eOut), .fOut(fOut)
  );

endmodule

// File: tb/ord2_engine_tb.sv
module ord2_engine_tb;

  localparam int PW = 16;
  localparam int CW = 12;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [PW-1:0] pIn = '0;
  logic [CW-1:0] capIn = '0;
  logic busy, done;
  logic [1:0] resCode;
  logic [PW-1:0] pOut, fOut;
  logic [CW-1:0] eOut;

  always #10 clk = ~clk;   // 50 MHz

  ord2_engine #(.PW(PW), .CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .pIn(pIn), .capIn(capIn),
    .busy(busy), .done(done), .resCode(resCode),
    .pOut(pOut), .eOut(eOut), .fOut(fOut)
  );

  typedef struct {
    int p; int code; int e; int f; int lat; int sc; bit glitch;
  } item_t;

  item_t expQ[$];
  int total = 0, bad = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic item_t model(int p, int cap);
    item_t it;
    int r;
    it.p = p; it.e = 0; it.f = 0; it.glitch = 0; it.sc = 0;
    if (p < 3 || (p % 2) == 0) begin
      it.code = 3; it.lat = 1;
      return it;
    end
    r = 2;
    for (int n = 2; n <= cap; n++) begin
      if (it.e == 0) begin
        r = (2 * r) % p;
        if (r == 1) it.e = n;
      end
    end
    if (it.e == 0) begin
      it.code = 1;
      it.lat  = 1 + ((cap < 1) ? 1 : cap);
    end else begin
      it.lat = it.e + ((p - 1) / it.e + 1) + 1;
      if ((p - 1) % it.e == 0) begin
        it.code = 0; it.f = (p - 1) / it.e;
      end else begin
        it.code = 2;
      end
    end
    return it;
  endfunction

  // driver: one job, optional foreign start while busy
  task automatic run(int p, int cap, bit glitch);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    it = model(p, cap);
    it.glitch = glitch;
    it.sc = cyc;
    expQ.push_back(it);
    pIn = PW'(p); capIn = CW'(cap); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      @(negedge clk);
      pIn = PW'(3); capIn = CW'(5); start = 1'b1;   // R9 foreign start
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        item_t it;
        string tc;
        int hp, he, hf, hc;
        if (expQ.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          it = expQ.pop_front();
          case (it.code)
            0: tc = "R5"; 1: tc = "R4"; 2: tc = "R6"; default: tc = "R2";
          endcase
          if (it.glitch) tc = "R9";
          chk(resCode == it.code, {tc, " code"}, resCode, it.code);
          chk(pOut == it.p, {tc, " p"}, pOut, it.p);
          chk(eOut == it.e, "R3 e", eOut, it.e);
          chk(fOut == it.f, {tc, " f"}, fOut, it.f);
          chk(busy == 1'b0, "R8 busy at done", busy, 0);
          chk(cyc - it.sc == it.lat, "R7 latency", cyc - it.sc, it.lat);
          hp = pOut; he = eOut; hf = fOut; hc = resCode;
          @(negedge clk);
          chk(done == 1'b0, "R8 pulse width", done, 0);
          chk(pOut == hp && eOut == he && fOut == hf && resCode == hc,
              "R8 hold", pOut, hp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 idle", {busy, done}, 0);
    chk(resCode == 0 && pOut == 0 && eOut == 0 && fOut == 0, "R1 outputs", pOut + eOut + fOut + resCode, 0);
    rstN = 1'b1;
    // R2 rejected inputs
    run(0, 2000, 0);
    run(1, 2000, 0);
    run(2, 2000, 0);
    run(10, 2000, 0);
    // R3/R5 small primes, R4 cap boundaries
    run(3, 2000, 0);
    run(7, 3, 0);
    run(7, 2, 0);
    run(5, 1, 0);
    run(5, 0, 0);
    // R6 composites whose order fails to divide p-1
    run(9, 2000, 0);
    run(15, 2000, 0);
    run(21, 2000, 0);
    // pseudoprime at the cap boundary
    run(341, 9, 0);
    run(341, 10, 0);
    // R9 foreign start during a long run
    run(101, 2000, 1);
    // full-width modulus
    run(65535, 4095, 0);
    // sweep odd candidates
    for (int p = 3; p < 200; p += 2) run(p, 2000, 0);
    @(negedge clk);
    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule